// File: doc/BRIEF.md
# Periodic Countdown Timer

This block is a down-counting timer peripheral reached through a small word-addressed register bus. Software loads a period value, which is copied straight into the counter. It then writes a control word whose start and stop bits take effect on that write. While the counter runs it falls by one on every clock. When a running counter sits at zero, the timer raises a timeout flag. In continuous mode the counter then reloads from the stored period and keeps running. In one-shot mode it halts instead.

A level interrupt follows the timeout flag, gated by an enable bit in the control word. Software acknowledges a timeout by writing anything to the status word. The live count is read through a read-only snapshot word, so the period value stays readable while the counter moves.

Top module: `countdown_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and `irq` is low.
- R2: Addresses are byte offsets. Status is at 0x0, control at 0x4, period at 0x8 and snapshot at 0xC. A write happens on a clock edge where `bus_wr` is high. `bus_rdata` is loaded on the edge where `bus_rd` is high, so it is valid the cycle after the strobe, and it holds its value while `bus_rd` is low.
- R3: In the status word, bit 0 is the timeout flag and bit 1 is the running flag; all other bits read 0. A write to status of any data clears the timeout flag. The running flag cannot be written.
- R4: A write to control stores the full 32-bit value, which reads back unchanged. In the control word, bit 0 is the interrupt enable, bit 1 selects continuous mode, bit 2 is start and bit 3 is stop. Start in the written value sets the counter running. Stop halts it. When both bits are set, the counter ends up stopped.
- R5: A write to period stores the value and loads the counter with it on the same edge, so a following snapshot read returns it.
- R6: While running, the count falls by one on each clock. At an edge where the counter is running and the count is zero, an expiry occurs and the timeout flag is set.
- R7: On an expiry in one-shot mode (control bit 1 clear), the running flag clears and the count stays at zero.
- R8: On an expiry in continuous mode, the counter reloads from the period register and keeps running. A period P therefore gives one expiry every P+1 clocks.
- R9: `irq` is high exactly while the timeout flag and control bit 0 are both set. It follows register writes and expiries one cycle after the edge that changes them.
- R10: Writes to the snapshot offset have no effect. Writes to unmapped addresses have no effect, and reads from them return zero. An address is unmapped if its low two bits are nonzero or if any bit at position 4 or above is set.
- R11: If an expiry and a status write fall on the same edge, the timeout flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with a 32-bit data path and a 6-bit address. This places aliases of the four registers at offsets 0x10 to 0x3F, and the decoder must treat them as unmapped. Because the default period width is kept, full-word control read-back is exercised. Periods of one to five clocks keep one-shot expiry, continuous reload, and a clear that collides with an expiry within a few edges. Every expected count is derived by counting edges from the start write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int REG_COUNT = 4;
    localparam int IDX_W     = 2;
    localparam int WORD_LSB  = 2;
    localparam int MAP_TOP   = WORD_LSB + IDX_W;

    typedef enum logic [IDX_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_SNAP   = 2'd3
    } reg_sel_e;

    localparam int CTL_IE    = 0;
    localparam int CTL_CONT  = 1;
    localparam int CTL_START = 2;
    localparam int CTL_STOP  = 3;

    localparam int STS_TO  = 0;
    localparam int STS_RUN = 1;
endpackage

// File: rtl/cdt_bus_decode.sv
module cdt_bus_decode
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] period_word,
    input  logic [DATA_W-1:0] snap_word,
    output logic              sts_wr,
    output logic              ctrl_wr,
    output logic              per_wr,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;

    logic                 mapped;
    logic [IDX_W-1:0]     idx;
    logic [REG_COUNT-1:0] hit;
    logic [DATA_W-1:0]    words [REG_COUNT];
    logic [DATA_W-1:0]    rd_word;

    // Aligned and nothing set above the four-word window
    assign mapped = (addr[WORD_LSB-1:0] == '0) && ((addr >> MAP_TOP) == '0);
    assign idx    = addr[MAP_TOP-1:WORD_LSB];

    assign words[SEL_STATUS] = status_word;
    assign words[SEL_CTRL]   = ctrl_word;
    assign words[SEL_PERIOD] = period_word;
    assign words[SEL_SNAP]   = snap_word;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_hit
        assign hit[g] = mapped && (idx == IDX_W'(g));
    end

    // Snapshot has no write strobe: writes there are dropped
    assign sts_wr  = wr_en && hit[SEL_STATUS];
    assign ctrl_wr = wr_en && hit[SEL_CTRL];
    assign per_wr  = wr_en && hit[SEL_PERIOD];

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (hit[i]) rd_word = rd_word | words[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_wr, ctrl_wr, per_wr})); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !mapped |=> rdata == '0); // R10
    AST_UNMAPPED_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> !(sts_wr || ctrl_wr || per_wr)); // R10
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              ctrl_wr,
    input  logic              start_bit,
    input  logic              stop_bit,
    input  logic              cont_mode,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              expire
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign expire = st_q.run && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (expire) begin
            if (cont_mode) st_d.cnt = reload_val;
            else           st_d.run = 1'b0;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        // A period write overrides the counting step
        if (load_en) st_d.cnt = load_val;
        // Control write decides run state; stop applied last wins
        if (ctrl_wr) begin
            if (start_bit) st_d.run = 1'b1;
            if (stop_bit)  st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        running && count != '0 && !load_en |=> count == $past(count) - 1'b1); // R6
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !cont_mode && !ctrl_wr && !load_en |=> !running && count == '0); // R7
    AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire && cont_mode && !load_en && !ctrl_wr |=> running && count == $past(reload_val)); // R8
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && stop_bit |=> !running); // R4
    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count == $past(load_val)); // R5
endmodule

// File: rtl/cdt_reg_file.sv
module cdt_reg_file
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sts_wr,
    input  logic              ctrl_wr,
    input  logic              per_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    input  logic              running,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] period_word,
    output logic [DATA_W-1:0] status_word,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] period;
        logic              tmo;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.ctrl   = wdata;
        if (per_wr)  st_d.period = wdata;
        // Expiry set outranks an acknowledge on the same edge
        if (expire)      st_d.tmo = 1'b1;
        else if (sts_wr) st_d.tmo = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_word          = '0;
        status_word[STS_TO]  = st_q.tmo;
        status_word[STS_RUN] = running;
    end

    assign ctrl_word   = st_q.ctrl;
    assign period_word = st_q.period;
    assign irq         = st_q.tmo && st_q.ctrl[CTL_IE];

    AST_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status_word[STS_TO]); // R11
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr && !expire |=> !irq); // R3
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire) || $past(ctrl_wr)); // R9
    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_word == $past(wdata)); // R4
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              sts_wr, ctrl_wr, per_wr;
    logic [DATA_W-1:0] status_word, ctrl_word, period_word, count;
    logic              running, expire;

    cdt_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .rd_en       (bus_rd),
        .addr        (bus_addr),
        .status_word (status_word),
        .ctrl_word   (ctrl_word),
        .period_word (period_word),
        .snap_word   (count),
        .sts_wr      (sts_wr),
        .ctrl_wr     (ctrl_wr),
        .per_wr      (per_wr),
        .rdata       (bus_rdata)
    );

    cdt_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sts_wr      (sts_wr),
        .ctrl_wr     (ctrl_wr),
        .per_wr      (per_wr),
        .wdata       (bus_wdata),
        .expire      (expire),
        .running     (running),
        .ctrl_word   (ctrl_word),
        .period_word (period_word),
        .status_word (status_word),
        .irq         (irq)
    );

    cdt_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (per_wr),
        .load_val   (bus_wdata),
        .ctrl_wr    (ctrl_wr),
        .start_bit  (bus_wdata[CTL_START]),
        .stop_bit   (bus_wdata[CTL_STOP]),
        .cont_mode  (ctrl_word[CTL_CONT]),
        .reload_val (period_word),
        .count      (count),
        .running    (running),
        .expire     (expire)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq && !running && count == '0); // R1
endmodule

// File: tb/countdown_timer_tb_top.sv
module countdown_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_STS = 6'h00, A_CTL = 6'h04, A_PER = 6'h08, A_SNAP = 6'h0C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    countdown_timer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        check("R1 irq", {31'b0, irq}, 0);
        rd(A_STS, v);  check("R1 status", v, 0);
        rd(A_CTL, v);  check("R1 control", v, 0);
        rd(A_PER, v);  check("R1 period", v, 0);
        rd(A_SNAP, v); check("R1 snapshot", v, 0);
        idle(2);
        check("R2 rdata holds", bus_rdata, 0);
    endtask

    task automatic t_load_and_map;
        logic [DW-1:0] v;
        wr(A_PER, 32'h1234);
        rd(A_SNAP, v); check("R5 snapshot after period write", v, 32'h1234);
        rd(A_PER, v);  check("R5 period readback", v, 32'h1234);
        idle(2);
        check("R2 rdata held between reads", bus_rdata, 32'h1234);
        wr(A_CTL, 32'h0000_000C);
        rd(A_STS, v);  check("R4 start+stop leaves stopped", v, 0);
        rd(A_SNAP, v); check("R4 counter frozen", v, 32'h1234);
        wr(A_CTL, 32'hABCD_0000);
        rd(A_CTL, v);  check("R4 full control readback", v, 32'hABCD_0000);
        wr(6'h18, 32'h77);
        rd(A_PER, v);  check("R10 unmapped write ignored", v, 32'h1234);
        rd(6'h18, v);  check("R10 unmapped read zero", v, 0);
        rd(A_PER, v);
        rd(6'h09, v);  check("R10 misaligned read zero", v, 0);
        wr(A_SNAP, 32'h55);
        rd(A_SNAP, v); check("R10 snapshot write ignored", v, 32'h1234);
    endtask

    task automatic t_decrement;
        logic [DW-1:0] v;
        wr(A_PER, 5);
        wr(A_CTL, 32'h4);
        rd(A_SNAP, v); check("R6 first snapshot", v, 5);
        rd(A_SNAP, v); check("R6 decrement by one", v, 4);
        rd(A_STS, v);  check("R3 running flag", v, 32'h2);
        wr(A_CTL, 32'h8);
        rd(A_SNAP, v); check("R4 stop freezes", v, 1);
        idle(3);
        rd(A_SNAP, v); check("R4 stays stopped", v, 1);
    endtask

    task automatic t_oneshot;
        logic [DW-1:0] v;
        wr(A_PER, 3);
        wr(A_CTL, 32'h5);
        idle(3);
        check("R6 no timeout before expiry", {31'b0, irq}, 0);
        idle(1);
        check("R9 irq on expiry", {31'b0, irq}, 1);
        rd(A_STS, v);  check("R7 one-shot halts", v, 32'h1);
        rd(A_SNAP, v); check("R7 count at zero", v, 0);
        idle(2);
        rd(A_SNAP, v); check("R7 no reload", v, 0);
        wr(A_STS, 32'hFFFF_FFFF);
        check("R3 status write clears irq", {31'b0, irq}, 0);
        rd(A_STS, v);  check("R3 timeout cleared", v, 0);
    endtask

    task automatic t_irq_gate;
        logic [DW-1:0] v;
        wr(A_PER, 1);
        wr(A_CTL, 32'h4);
        idle(3);
        check("R9 masked irq", {31'b0, irq}, 0);
        rd(A_STS, v); check("R9 timeout set while masked", v, 32'h1);
        wr(A_CTL, 32'h1);
        check("R9 enabling raises irq", {31'b0, irq}, 1);
        wr(A_STS, 0);
        check("R3 zero write clears", {31'b0, irq}, 0);
    endtask

    task automatic t_continuous;
        logic [DW-1:0] v;
        wr(A_PER, 2);
        wr(A_CTL, 32'h7);
        idle(2);
        check("R8 before first expiry", {31'b0, irq}, 0);
        idle(1);
        check("R8 first expiry", {31'b0, irq}, 1);
        rd(A_SNAP, v); check("R8 reloaded from period", v, 2);
        rd(A_STS, v);  check("R8 keeps running", v, 32'h3);
        wr(A_STS, 0);
        check("R11 clear colliding with expiry", {31'b0, irq}, 1);
        wr(A_STS, 0);
        check("R3 clear after collision", {31'b0, irq}, 0);
        wr(A_CTL, 32'h8);
        idle(3);
        rd(A_STS, v);  check("R4 stop in continuous mode", v, 0);
        rd(A_SNAP, v); check("R8 count at stop", v, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_load_and_map();
        t_decrement();
        t_oneshot();
        t_irq_gate();
        t_continuous();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule